// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM with 64 words of 16 bits. It sits behind a chip-select, serial-clock, data-in and data-out pin set. A fast system clock synchronizes and oversamples the three input pins. Each transaction opens with chip select high and a framing 1 bit. A two-bit operation code and a six-bit word address follow. Some operations then take a 16-bit data field. Data in is sampled on rising serial-clock edges, and the data-out pin also changes on those edges.

Programming operations run as a self-timed cycle lasting `PROG_CYCLES` system clocks. These are single-word write, single-word erase, fill-all and erase-all. They are accepted only after a sticky enable command and refused after a disable command. To poll the cycle, the host drops chip select and raises it again. Data out then reports busy or ready. The tri-state data-out pin is modelled as a value plus a drive-enable output.

Top module: `serial_eeprom_model`

## Requirements
- R1: A command starts only at the first serial-clock rising edge with data in = 1 after chip select goes high; 0 bits before it are skipped. The next two bits form the operation code and the six bits after that form the address, MSB first.
- R2: Operation code 10 reads the addressed word. Data out presents one 0 bit, then the 16 data bits MSB first, and advances one bit per serial-clock rising edge. Reading works whether programming is enabled or not.
- R3: After reset every word holds 16'hFFFF, programming is disabled and do_oe_o is 0.
- R4: Operation code 00 with address bits [5:4] = 11 enables programming and with [5:4] = 00 disables it. The enable state persists across any number of other commands until disabled or reset.
- R5: While programming is disabled, write, erase, fill-all and erase-all leave every word unchanged and start no busy cycle.
- R6: Operation code 01 followed by 16 data bits (MSB first) stores that word at the address. Operation code 11 sets the addressed word to 16'hFFFF.
- R7: Operation code 00 with address bits [5:4] = 10 sets every word to 16'hFFFF. With [5:4] = 01 it takes 16 data bits and stores them in every word.
- R8: A programming operation is busy for PROG_CYCLES system clocks. If chip select goes low and then high during that time, data out is driven and shows 0 while busy and 1 once done. Commands clocked in during this status phase are ignored.
- R9: do_oe_o is 0 while chip select is low, and is 1 only during a read's output phase or a status phase.
- R10: Dropping chip select before a command's last bit has been clocked in abandons the command without changing any word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out value |
| do_oe_o | output | 1 | Drive enable for do_o; 0 means high impedance |

## Verification
The embedded properties check several rules on every cycle. Data out is released one cycle after chip select is seen low. A read always opens with the dummy 0. No busy cycle starts while programming is disabled or while a cycle is already running, and each start raises busy. Word contents and the ordering of the serial fields can only be shown by the bench's scenarios, which compare every read against a bench model of the memory. These scenarios cover random mixes of commands, the status poll across the end of the busy cycle, an aborted write, and the skipping of leading zeros.

// File: rtl/eeprom_model_pkg.sv
package eeprom_model_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FRAME,
        PH_OPC,
        PH_ADDR,
        PH_DATA,
        PH_READ,
        PH_STATUS,
        PH_HOLD
    } phase_e;

    localparam logic [1:0] OPC_EXT   = 2'b00;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_ERASE = 2'b11;

    localparam logic [1:0] EXT_LOCK   = 2'b00;
    localparam logic [1:0] EXT_FILL   = 2'b01;
    localparam logic [1:0] EXT_WIPE   = 2'b10;
    localparam logic [1:0] EXT_UNLOCK = 2'b11;

endpackage

// File: rtl/pin_sampler.sv
module pin_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_s,
    output logic di_s,
    output logic sk_rise
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] cs_q, sk_q, di_q;
    logic                   sk_last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q      <= '0;
            sk_q      <= '0;
            di_q      <= '0;
            sk_last_q <= 1'b0;
        end else begin
            cs_q      <= {cs_q[TOP-1:0], cs_i};
            sk_q      <= {sk_q[TOP-1:0], sk_i};
            di_q      <= {di_q[TOP-1:0], di_i};
            sk_last_q <= sk_q[TOP];
        end
    end

    assign cs_s    = cs_q[TOP];
    assign di_s    = di_q[TOP];
    assign sk_rise = sk_q[TOP] & ~sk_last_q;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
    parameter int CYCLES = 300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R8: every accepted programming operation makes the device busy
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
endmodule

// File: rtl/word_array.sv
module word_array #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_one,
    input  logic              wr_all,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[w] <= '1;
            end else if (wr_all || (wr_one && wr_addr == ADDR_W'(w))) begin
                mem_q[w] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/serial_eeprom_model.sv
module serial_eeprom_model
    import eeprom_model_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int PROG_CYCLES = 300,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int MAXB  = (DATA_W > ADDR_W) ? DATA_W : ADDR_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] shift;
        logic [DATA_W:0]   rd_sr;
        logic              en;
        logic              all;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              cs_s, di_s, sk_rise;
    logic              busy, prog_start;
    logic              wr_one, wr_all;
    logic [ADDR_W-1:0] wr_addr, addr_next;
    logic [DATA_W-1:0] wr_data, rd_data, data_next;
    logic              rd_phase;

    pin_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs_i),
        .sk_i    (sk_i),
        .di_i    (di_i),
        .cs_s    (cs_s),
        .di_s    (di_s),
        .sk_rise (sk_rise)
    );

    prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (prog_start),
        .busy  (busy)
    );

    word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_one  (wr_one),
        .wr_all  (wr_all),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (addr_next),
        .rd_data (rd_data)
    );

    assign addr_next = {ctl_q.addr[ADDR_W-2:0], di_s};
    assign data_next = {ctl_q.shift[DATA_W-2:0], di_s};

    always_comb begin
        ctl_d      = ctl_q;
        prog_start = 1'b0;
        wr_one     = 1'b0;
        wr_all     = 1'b0;
        wr_addr    = ctl_q.addr;
        wr_data    = data_next;

        if (!cs_s) begin
            ctl_d.phase = PH_IDLE;
        end else begin
            unique case (ctl_q.phase)
                PH_IDLE: begin
                    ctl_d.phase = busy ? PH_STATUS : PH_FRAME;
                    ctl_d.cnt   = '0;
                end
                PH_FRAME: begin
                    if (sk_rise && di_s) begin
                        ctl_d.phase = PH_OPC;
                        ctl_d.cnt   = '0;
                    end
                end
                PH_OPC: begin
                    if (sk_rise) begin
                        ctl_d.opc = {ctl_q.opc[0], di_s};
                        if (ctl_q.cnt == CNT_W'(1)) begin
                            ctl_d.phase = PH_ADDR;
                            ctl_d.cnt   = '0;
                        end else begin
                            ctl_d.cnt = ctl_q.cnt + 1'b1;
                        end
                    end
                end
                PH_ADDR: begin
                    if (sk_rise) begin
                        ctl_d.addr = addr_next;
                        ctl_d.cnt  = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == CNT_W'(ADDR_W - 1)) begin
                            ctl_d.cnt   = '0;
                            ctl_d.phase = PH_HOLD;
                            ctl_d.all   = 1'b0;
                            unique case (ctl_q.opc)
                                OPC_READ: begin
                                    ctl_d.rd_sr = {1'b0, rd_data};
                                    ctl_d.phase = PH_READ;
                                end
                                OPC_WRITE: ctl_d.phase = PH_DATA;
                                OPC_ERASE: begin
                                    if (ctl_q.en && !busy) begin
                                        wr_one     = 1'b1;
                                        wr_addr    = addr_next;
                                        wr_data    = '1;
                                        prog_start = 1'b1;
                                    end
                                end
                                default: begin
                                    unique case (addr_next[ADDR_W-1 -: 2])
                                        EXT_UNLOCK: ctl_d.en = 1'b1;
                                        EXT_LOCK:   ctl_d.en = 1'b0;
                                        EXT_WIPE: begin
                                            if (ctl_q.en && !busy) begin
                                                wr_all     = 1'b1;
                                                wr_data    = '1;
                                                prog_start = 1'b1;
                                            end
                                        end
                                        default: begin
                                            ctl_d.phase = PH_DATA;
                                            ctl_d.all   = 1'b1;
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                end
                PH_DATA: begin
                    if (sk_rise) begin
                        ctl_d.shift = data_next;
                        ctl_d.cnt   = ctl_q.cnt + 1'b1;
                        if (ctl_q.cnt == CNT_W'(DATA_W - 1)) begin
                            ctl_d.phase = PH_HOLD;
                            ctl_d.cnt   = '0;
                            if (ctl_q.en && !busy) begin
                                wr_one     = !ctl_q.all;
                                wr_all     = ctl_q.all;
                                prog_start = 1'b1;
                            end
                        end
                    end
                end
                PH_READ: begin
                    if (sk_rise) begin
                        ctl_d.rd_sr = {ctl_q.rd_sr[DATA_W-1:0], 1'b0};
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.phase <= PH_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_phase = (ctl_q.phase == PH_READ);
    assign do_oe_o  = rd_phase || (ctl_q.phase == PH_STATUS);
    assign do_o     = (ctl_q.phase == PH_STATUS) ? !busy : ctl_q.rd_sr[DATA_W];

    // R9: data out released once chip select is seen low
    a_r9_hiz_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe_o);

    // R2: the output phase of a read opens with the dummy zero
    a_r2_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_phase) |-> !do_o);

    // R5: no programming cycle while disabled
    a_r5_locked_no_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.en |-> !prog_start);

    // R8: a running cycle is never restarted
    a_r8_no_restart_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy);
endmodule

// File: tb/serial_eeprom_model_bench.sv
module serial_eeprom_model_bench;
    localparam int PROG = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, doe;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    logic [15:0] ref_mem [64];
    bit          ref_en;

    always #5 clk = ~clk;

    serial_eeprom_model #(.PROG_CYCLES(PROG)) u_serial_eeprom_model (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .do_o    (dout),
        .do_oe_o (doe)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        di = b; tick(3);
        sk = 1'b1; tick(4);
        sk = 1'b0; tick(3);
    endtask

    task automatic cs_up();
        cs = 1'b1; tick(4);
    endtask

    task automatic cs_down();
        cs = 1'b0; tick(4);
    endtask

    task automatic send_hdr(input logic [1:0] op, input logic [5:0] a);
        send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 5; i >= 0; i--) send_bit(a[i]);
    endtask

    task automatic send_data(input logic [15:0] d, input int nbits);
        for (int i = 15; i > 15 - nbits; i--) send_bit(d[i]);
    endtask

    function automatic logic [15:0] expect_word(input logic [5:0] a);
        return ref_mem[a];
    endfunction

    task automatic do_read(input logic [5:0] a, input string req, input int lead_zeros);
        logic [15:0] got;
        cs_up();
        for (int i = 0; i < lead_zeros; i++) send_bit(1'b0);
        send_hdr(2'b10, a);
        check({req, " dummy bit"}, {30'd0, doe, dout}, {30'd0, 1'b1, 1'b0});
        for (int i = 15; i >= 0; i--) begin
            send_bit(1'b0);
            got[i] = dout;
        end
        check({req, " read word"}, {16'd0, got}, {16'd0, expect_word(a)});
        cs_down();
    endtask

    task automatic program_wait();
        cs_down();
        tick(PROG + 10);
    endtask

    task automatic cmd_ext(input logic [1:0] sub, input logic [15:0] d);
        cs_up();
        send_hdr(2'b00, {sub, 4'b1010});
        if (sub == 2'b01) send_data(d, 16);
        if (ref_en && sub == 2'b10) for (int w = 0; w < 64; w++) ref_mem[w] = 16'hFFFF;
        if (ref_en && sub == 2'b01) for (int w = 0; w < 64; w++) ref_mem[w] = d;
        if (sub == 2'b11) ref_en = 1'b1;
        if (sub == 2'b00) ref_en = 1'b0;
        program_wait();
    endtask

    task automatic cmd_write(input logic [5:0] a, input logic [15:0] d);
        cs_up();
        send_hdr(2'b01, a);
        send_data(d, 16);
        if (ref_en) ref_mem[a] = d;
        program_wait();
    endtask

    task automatic cmd_erase(input logic [5:0] a);
        cs_up();
        send_hdr(2'b11, a);
        if (ref_en) ref_mem[a] = 16'hFFFF;
        program_wait();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [5:0]  a;
        logic [15:0] d;
        void'($urandom(32'h0000_5eed));
        for (int w = 0; w < 64; w++) ref_mem[w] = 16'hFFFF;
        ref_en = 1'b0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R3 reset state, R9 released while deselected
        check("R3 oe after reset", {31'd0, doe}, 32'd0);
        do_read(6'd0, "R3", 0);
        check("R9 oe with cs low", {31'd0, doe}, 32'd0);

        // R5 write refused while disabled; R2 read works while disabled
        cmd_write(6'd5, 16'h1234);
        do_read(6'd5, "R5 R2", 0);
        cmd_erase(6'd6);
        cmd_ext(2'b01, 16'h0000);
        do_read(6'd6, "R5", 0);

        // R4 enable, R6 write and erase
        cmd_ext(2'b11, 16'h0);
        cmd_write(6'd5, 16'hA5C3);
        do_read(6'd5, "R6 write", 0);
        cmd_write(6'd63, 16'h0001);
        do_read(6'd63, "R6 top word", 0);
        cmd_erase(6'd5);
        do_read(6'd5, "R6 erase", 0);

        // R1 leading zeros skipped
        cmd_write(6'd9, 16'h8001);
        do_read(6'd9, "R1", 3);

        // R8 status poll and commands ignored while busy
        cs_up();
        send_hdr(2'b01, 6'd12);
        send_data(16'h0F0F, 16);
        ref_mem[12] = 16'h0F0F;
        cs_down();
        cs_up();
        tick(2);
        check("R8 busy status", {30'd0, doe, dout}, {30'd0, 1'b1, 1'b0});
        send_hdr(2'b01, 6'd13);
        send_data(16'h0000, 16);
        tick(PROG);
        check("R8 ready status", {30'd0, doe, dout}, {30'd0, 1'b1, 1'b1});
        cs_down();
        check("R9 oe after status", {31'd0, doe}, 32'd0);
        do_read(6'd12, "R8 data", 0);
        do_read(6'd13, "R8 ignored", 0);

        // R10 abort mid data field
        cs_up();
        send_hdr(2'b01, 6'd20);
        send_data(16'h0000, 8);
        cs_down();
        tick(PROG + 10);
        do_read(6'd20, "R10", 0);

        // R7 fill-all and erase-all
        cmd_ext(2'b01, 16'h3C3C);
        do_read(6'd0, "R7 fill", 0);
        do_read(6'd47, "R7 fill", 0);
        cmd_ext(2'b10, 16'h0);
        do_read(6'd33, "R7 wipe", 0);

        // R4 disable then refused write
        cmd_ext(2'b00, 16'h0);
        cmd_write(6'd2, 16'h0000);
        do_read(6'd2, "R4 disabled", 0);
        cmd_ext(2'b11, 16'h0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int sel;
            sel = int'($urandom % 8);
            a   = 6'($urandom);
            d   = 16'($urandom);
            case (sel)
                0, 1, 2: do_read(a, "R2 random", 0);
                3:       cmd_write(a, d);
                4:       cmd_erase(a);
                5:       cmd_ext(2'b11, 16'h0);
                6:       cmd_ext(2'b00, 16'h0);
                default: cmd_ext(($urandom % 2) ? 2'b01 : 2'b10, d);
            endcase
        end
        for (int w = 0; w < 64; w += 3) do_read(6'(w), "R6 R7 scan", 0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule